// File: doc/BRIEF.md
# Two-Port Handshake Sensor Responder

This block is the device side of a byte-wide sensor controller. A host reaches it through two single-byte ports: a data port and a command port. Every access is a polled exchange. The host writes a value, then polls for a fixed code that marks the next phase. It never reads from a flat register window. A sensor is named by a 16-bit address. The upper byte is the bank and the lower byte is the index within that bank. The sensor bytes sit in a small internal array that a loading port fills.

A read runs as follows. The host writes the bank to the data port while the block is ready. It waits for the data port to show the ready code again. It then writes the index to the command port and waits for the result code on the data port. Finally it reads the sensor byte from the command port. After every read the host runs a resynchronisation. It writes zero to the data port, waits for the sync code on the data port, then reads the sync mark from the command port. That final read returns the block to ready. Each code appears a configurable number of clock cycles after the write that asked for it, which keeps the host's polling loop busy.

The states are READY, BANK_WAIT, BANK_ACK, IDX_WAIT, RESULT, SYNC_WAIT and SYNC_ACK. The transitions are:

| From | Event | To |
|---|---|---|
| READY | data write | BANK_WAIT |
| BANK_WAIT | delay done | BANK_ACK |
| BANK_ACK | command write | IDX_WAIT |
| IDX_WAIT | delay done | RESULT |
| SYNC_WAIT | delay done | SYNC_ACK |
| SYNC_ACK | command read | READY |
| any state but READY | data write of 0x00 | SYNC_WAIT (this takes priority over every other event) |

Top module: `sensor_port_responder`

## Requirements
- R1: After reset the data port reads 0x08 and the command port reads 0x00.
- R2: A data-port write (port_sel=0) in READY latches wdata as the bank, 0x00 included. The data port then reads 0x00 until exactly ACK_DELAY clock edges after the write edge, and from then on reads 0x08.
- R3: A command-port write (port_sel=1) in BANK_ACK latches the index. The data port then reads 0x00 until exactly ACK_DELAY edges after that write edge, and from then on reads 0x01.
- R4: While the data port shows 0x01, a command-port read returns the array byte at position bank*NUM_INDEX+index.
- R5: A bank at or above NUM_BANKS, or an index at or above NUM_INDEX, gives a result byte of 0x00.
- R6: A command-port write made in READY or in BANK_WAIT is ignored. The state is unchanged, and the index that takes effect is the one written after the bank acknowledge.
- R7: A data-port write of 0x00 in any state other than READY starts a resync. The data port reads 0x00 for ACK_DELAY edges, then reads 0x09, and the command port reads 0xAC.
- R8: A command-port read while the data port shows 0x09 returns the block to READY at the next edge, so the data port reads 0x08.
- R9: rdata is 0x00 whenever rd_en is low. Reads of the data port have no effect on the state.
- R10: In RESULT, a data-port write of a nonzero value is ignored. The data port keeps 0x01 and the command port keeps the sensor byte.
- R11: A load with load_en high writes load_data at load_addr, where the upper byte is the bank and the lower byte is the index. Later reads return the new value. A load whose bank or index is out of range is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 0 selects the data port, 1 selects the command port |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data for the selected port; 0x00 when rd_en is low |
| load_en | input | 1 | Array load strobe |
| load_addr | input | 16 | Load address: bank in the upper byte, index in the lower byte |
| load_data | input | 8 | Byte to be loaded |

## Verification
The bench builds the block with ACK_DELAY=3, NUM_BANKS=4 and NUM_INDEX=8. A three-cycle delay makes the polling loops count a nonzero number of busy cycles, and that count is compared against the delay. It also leaves room to land a command write inside the bank-wait window. The 4-by-8 array is small enough for random addresses to fall past either limit often, so the out-of-range zero result and dropped loads are hit alongside in-range reads.

// File: rtl/spr_pkg.sv
package spr_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_BANK_WAIT,
        ST_BANK_ACK,
        ST_IDX_WAIT,
        ST_RESULT,
        ST_SYNC_WAIT,
        ST_SYNC_ACK
    } spr_state_e;

    localparam logic [7:0] CODE_READY     = 8'h08;
    localparam logic [7:0] CODE_BUSY      = 8'h00;
    localparam logic [7:0] CODE_RESULT    = 8'h01;
    localparam logic [7:0] CODE_SYNC_DATA = 8'h09;
    localparam logic [7:0] CODE_SYNC_CMD  = 8'hAC;
    localparam logic [7:0] CODE_CMD_IDLE  = 8'h00;
    localparam logic [7:0] RESYNC_VALUE   = 8'h00;

    localparam logic PORT_DATA = 1'b0;
    localparam logic PORT_CMD  = 1'b1;

endpackage

// File: rtl/spr_delay.sv
module spr_delay #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY - 1);

    logic [CW-1:0] remain;

    // Loaded on the write edge; done goes high once DELAY-1 further edges
    // have passed, so the FSM leaves its wait state DELAY edges after the write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= LOAD_VAL;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

endmodule

// File: rtl/spr_sensor_array.sv
module spr_sensor_array #(
    parameter int NUM_BANKS = 8,
    parameter int NUM_INDEX = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_en,
    input  logic [15:0] load_addr,
    input  logic [7:0]  load_data,
    input  logic [7:0]  rd_bank,
    input  logic [7:0]  rd_index,
    output logic [7:0]  rd_byte
);
    localparam int DEPTH = NUM_BANKS * NUM_INDEX;
    localparam int AW    = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam logic [8:0] BANK_LIM = 9'(NUM_BANKS);
    localparam logic [8:0] IDX_LIM  = 9'(NUM_INDEX);

    logic [7:0] cells [DEPTH];

    logic [7:0]    ld_bank;
    logic [7:0]    ld_index;
    logic          ld_hit;
    logic [AW-1:0] ld_pos;
    logic          rd_hit;
    logic [AW-1:0] rd_pos;

    function automatic logic in_range(input logic [7:0] b, input logic [7:0] i);
        return ({1'b0, b} < BANK_LIM) && ({1'b0, i} < IDX_LIM);
    endfunction

    function automatic logic [AW-1:0] flat_pos(input logic [7:0] b, input logic [7:0] i);
        int lin;
        lin = int'(b) * NUM_INDEX + int'(i);
        return AW'(lin);
    endfunction

    assign ld_bank  = load_addr[15:8];
    assign ld_index = load_addr[7:0];
    assign ld_hit   = load_en && in_range(ld_bank, ld_index);
    assign ld_pos   = flat_pos(ld_bank, ld_index);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                cells[e] <= 8'h00;
            end
        end else if (ld_hit) begin
            cells[ld_pos] <= load_data;
        end
    end

    assign rd_hit  = in_range(rd_bank, rd_index);
    assign rd_pos  = flat_pos(rd_bank, rd_index);
    assign rd_byte = rd_hit ? cells[rd_pos] : 8'h00;

endmodule

// File: rtl/spr_fsm.sv
module spr_fsm
    import spr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    input  logic [7:0] sensor_byte,
    input  logic       delay_done,
    output logic       delay_start,
    output spr_state_e state,
    output logic [7:0] bank,
    output logic [7:0] index,
    output logic [7:0] data_code,
    output logic [7:0] cmd_code
);
    spr_state_e state_q;
    spr_state_e state_d;

    logic data_wr;
    logic cmd_wr;
    logic cmd_rd;
    logic resync;

    assign data_wr = wr_en && (port_sel == PORT_DATA);
    assign cmd_wr  = wr_en && (port_sel == PORT_CMD);
    assign cmd_rd  = rd_en && (port_sel == PORT_CMD);
    assign resync  = data_wr && (wdata == RESYNC_VALUE) && (state_q != ST_READY);

    // Next state and delay start
    always_comb begin
        state_d     = state_q;
        delay_start = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (data_wr) begin
                    state_d     = ST_BANK_WAIT;
                    delay_start = 1'b1;
                end
            end
            ST_BANK_WAIT: begin
                if (delay_done) state_d = ST_BANK_ACK;
            end
            ST_BANK_ACK: begin
                if (cmd_wr) begin
                    state_d     = ST_IDX_WAIT;
                    delay_start = 1'b1;
                end
            end
            ST_IDX_WAIT: begin
                if (delay_done) state_d = ST_RESULT;
            end
            ST_RESULT: begin
                state_d = ST_RESULT;
            end
            ST_SYNC_WAIT: begin
                if (delay_done) state_d = ST_SYNC_ACK;
            end
            ST_SYNC_ACK: begin
                if (cmd_rd) state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
        if (resync) begin
            state_d     = ST_SYNC_WAIT;
            delay_start = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Address capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank  <= 8'h00;
            index <= 8'h00;
        end else begin
            if ((state_q == ST_READY) && data_wr) bank <= wdata;
            if ((state_q == ST_BANK_ACK) && cmd_wr && !resync) index <= wdata;
        end
    end

    // Port codes per state
    always_comb begin
        data_code = CODE_BUSY;
        cmd_code  = CODE_CMD_IDLE;
        unique case (state_q)
            ST_READY, ST_BANK_ACK: data_code = CODE_READY;
            ST_BANK_WAIT, ST_IDX_WAIT, ST_SYNC_WAIT: data_code = CODE_BUSY;
            ST_RESULT: begin
                data_code = CODE_RESULT;
                cmd_code  = sensor_byte;
            end
            ST_SYNC_ACK: begin
                data_code = CODE_SYNC_DATA;
                cmd_code  = CODE_SYNC_CMD;
            end
            default: data_code = CODE_BUSY;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sensor_port_responder.sv
module sensor_port_responder
    import spr_pkg::*;
#(
    parameter int ACK_DELAY = 4,
    parameter int NUM_BANKS = 8,
    parameter int NUM_INDEX = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_sel,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        load_en,
    input  logic [15:0] load_addr,
    input  logic [7:0]  load_data
);
    spr_state_e state;
    logic [7:0] bank;
    logic [7:0] index;
    logic [7:0] data_code;
    logic [7:0] cmd_code;
    logic [7:0] sensor_byte;
    logic       delay_start;
    logic       delay_done;

    spr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_sel    (port_sel),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wdata       (wdata),
        .sensor_byte (sensor_byte),
        .delay_done  (delay_done),
        .delay_start (delay_start),
        .state       (state),
        .bank        (bank),
        .index       (index),
        .data_code   (data_code),
        .cmd_code    (cmd_code)
    );

    spr_delay #(.DELAY(ACK_DELAY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .start (delay_start),
        .done  (delay_done)
    );

    spr_sensor_array #(.NUM_BANKS(NUM_BANKS), .NUM_INDEX(NUM_INDEX)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .rd_bank   (bank),
        .rd_index  (index),
        .rd_byte   (sensor_byte)
    );

    always_comb begin
        if (!rd_en) begin
            rdata = 8'h00;
        end else if (port_sel == PORT_CMD) begin
            rdata = cmd_code;
        end else begin
            rdata = data_code;
        end
    end

endmodule

// File: rtl/spr_checker.sv
module spr_checker
    import spr_pkg::*;
#(
    parameter int ACK_DELAY = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       port_sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input spr_state_e state,
    input logic [7:0] data_code
);
    int wait_cycles;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cycles <= 0;
        end else if (state == ST_BANK_WAIT || state == ST_IDX_WAIT || state == ST_SYNC_WAIT) begin
            wait_cycles <= wait_cycles + 1;
        end else begin
            wait_cycles <= 0;
        end
    end

    assert_reset_ready_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> data_code == CODE_READY);

    assert_bank_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && wr_en && port_sel == PORT_DATA) |=> data_code == CODE_BUSY);

    assert_bank_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BANK_ACK && $past(state) == ST_BANK_WAIT) |-> wait_cycles == ACK_DELAY);

    assert_result_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESULT && $past(state) == ST_IDX_WAIT) |-> wait_cycles == ACK_DELAY);

    assert_cmd_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && wr_en && port_sel == PORT_CMD) |=> state == ST_READY);

    assert_sync_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY && wr_en && port_sel == PORT_DATA && wdata == RESYNC_VALUE)
        |=> data_code == CODE_BUSY);

    assert_sync_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC_ACK && rd_en && port_sel == PORT_CMD && !wr_en)
        |=> data_code == CODE_READY);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESULT && !(wr_en && port_sel == PORT_DATA && wdata == RESYNC_VALUE))
        |=> state == ST_RESULT);

endmodule

bind sensor_port_responder spr_checker #(.ACK_DELAY(ACK_DELAY)) u_spr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .state     (state),
    .data_code (data_code)
);

// File: tb/tb_sensor_port_responder.sv
module tb_sensor_port_responder;

    localparam int CLK_PERIOD = 10;
    localparam int ACK_DELAY  = 3;
    localparam int NB         = 4;
    localparam int NI         = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        load_en = 1'b0;
    logic [15:0] load_addr = 16'h0000;
    logic [7:0]  load_data = 8'h00;

    logic [7:0] shadow [NB*NI];
    int compared = 0;
    int mismatched = 0;
    bit reported = 1'b0;

    sensor_port_responder #(.ACK_DELAY(ACK_DELAY), .NUM_BANKS(NB), .NUM_INDEX(NI)) dut (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_byte(input int b, input int i);
        if (b < NB && i < NI) return shadow[b*NI+i];
        return 8'h00;
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        port_sel = sel; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic poll_data(input logic [7:0] code, output int cyc);
        port_sel = 1'b0; rd_en = 1'b1;
        #1;
        cyc = 0;
        while (rdata !== code && cyc < 64) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd_en = 1'b0;
    endtask

    task automatic read_port(input logic sel, output logic [7:0] v);
        @(negedge clk);
        port_sel = sel; rd_en = 1'b1;
        #1;
        v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek_data(output logic [7:0] v);
        port_sel = 1'b0; rd_en = 1'b1;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic load_byte(input int b, input int i, input logic [7:0] v);
        @(negedge clk);
        load_en = 1'b1; load_addr = {8'(b), 8'(i)}; load_data = v;
        @(negedge clk);
        load_en = 1'b0;
        if (b < NB && i < NI) shadow[b*NI+i] = v;
    endtask

    task automatic resync();
        int cyc;
        logic [7:0] v;
        do_write(1'b0, 8'h00);
        poll_data(8'h09, cyc);
        chk_int("R7 sync code latency", cyc, ACK_DELAY);
        read_port(1'b1, v);
        chk8("R7 sync mark on command port", v, 8'hAC);
        peek_data(v);
        chk8("R8 ready after sync mark read", v, 8'h08);
    endtask

    task automatic host_read(input int b, input int i);
        int cyc;
        logic [7:0] v;
        do_write(1'b0, 8'(b));
        poll_data(8'h08, cyc);
        chk_int("R2 bank ack latency", cyc, ACK_DELAY);
        do_write(1'b1, 8'(i));
        poll_data(8'h01, cyc);
        chk_int("R3 result latency", cyc, ACK_DELAY);
        read_port(1'b1, v);
        if (b < NB && i < NI) chk8("R4 sensor byte", v, exp_byte(b, i));
        else chk8("R5 out-of-range byte", v, 8'h00);
        resync();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int cyc;
        logic [7:0] v;
        void'($urandom(32'd4242));
        for (int k = 0; k < NB*NI; k++) shadow[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9 reset state
        peek_data(v);
        chk8("R1 data port after reset", v, 8'h08);
        port_sel = 1'b1; rd_en = 1'b1; #1;
        chk8("R1 command port after reset", rdata, 8'h00);
        rd_en = 1'b0; #1;
        chk8("R9 idle rdata", rdata, 8'h00);

        // R11 preload with random bytes
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < NI; i++)
                load_byte(b, i, 8'($urandom_range(0, 255)));

        // R6 command write in READY ignored; bank 0 selectable (R2)
        do_write(1'b1, 8'h03);
        peek_data(v);
        chk8("R6 command write in READY ignored", v, 8'h08);
        host_read(0, 3);

        // R6 command write during bank wait ignored
        do_write(1'b0, 8'h01);
        do_write(1'b1, 8'h05);
        poll_data(8'h08, cyc);
        chk_int("R6 bank ack after early command write", cyc, ACK_DELAY - 2);
        do_write(1'b1, 8'h06);
        poll_data(8'h01, cyc);
        chk_int("R3 result latency", cyc, ACK_DELAY);
        read_port(1'b1, v);
        chk8("R6 later index takes effect", v, exp_byte(1, 6));
        resync();

        // R10 nonzero data write in RESULT ignored
        do_write(1'b0, 8'h02);
        poll_data(8'h08, cyc);
        do_write(1'b1, 8'h02);
        poll_data(8'h01, cyc);
        do_write(1'b0, 8'h33);
        peek_data(v);
        chk8("R10 data code kept", v, 8'h01);
        rd_en = 1'b0; #1;
        chk8("R9 rdata zero in RESULT with rd_en low", rdata, 8'h00);
        read_port(1'b1, v);
        chk8("R10 sensor byte kept", v, exp_byte(2, 2));
        resync();

        // R7 resync from BANK_ACK
        do_write(1'b0, 8'h03);
        poll_data(8'h08, cyc);
        chk_int("R2 bank ack latency", cyc, ACK_DELAY);
        resync();

        // R5 out-of-range bank and index
        host_read(5, 1);
        host_read(1, 9);
        // R11 out-of-range load dropped, in-range overwrite seen
        load_byte(4, 0, 8'h5A);
        host_read(4, 0);
        load_byte(3, 7, 8'hC3);
        host_read(3, 7);

        // Random reads
        for (int n = 0; n < 25; n++) begin
            host_read(int'($urandom_range(0, NB)), int'($urandom_range(0, NI)));
        end

        report();
    end

endmodule